// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial EEPROM whose word address is 17 bits wide, enough for 131,072 bytes. Both bus lines pass through a synchroniser and a glitch filter. The filtered lines feed an edge and START/STOP detector. A state machine then decodes the device byte, the two address bytes, the write data and the read data. The pad is open-drain: the block pulls SDA low through `sda_oe` and otherwise releases it.

A write transaction commits its bytes into a behavioural byte array. Once the STOP arrives, a self-timed write cycle begins. It is modelled by a counter of `WR_CYCLES` system clocks, and during it the device ignores its own address. Reads come in three forms: current-address reads, random reads (a dummy write of the address, then a repeated START) and sequential reads. The behavioural array keeps 2^`ARRAY_AW` bytes and is indexed by the low bits of the 17-bit counter, so a smaller model aliases the upper addresses. Setting `ARRAY_AW` = `ADDR_W` gives the full array.

States:
- `ST_IDLE`: waiting for START.
- `ST_DEV`: shifting in the device byte. Goes to `ST_DEV_ACK` on a match while not busy, otherwise to `ST_IDLE`.
- `ST_DEV_ACK`: acknowledging the device byte. Goes to `ST_AHI` for a write or `ST_RDAT` for a read.
- `ST_AHI` / `ST_AHI_ACK`: the high address byte and its acknowledge.
- `ST_ALO` / `ST_ALO_ACK`: the low address byte and its acknowledge, which loads the counter.
- `ST_WDAT` / `ST_WDAT_ACK`: a data byte, then a commit and acknowledge. Loops back to `ST_WDAT`.
- `ST_RDAT`: eight bits driven out.
- `ST_RACK`: the master's acknowledge. Returns to `ST_RDAT` on ACK, or goes to `ST_IDLE` on NACK.

Any START moves the machine to `ST_DEV`, and any STOP moves it to `ST_IDLE`.

Top module: `eep2w_slave`

## Requirements
- R1: After reset, and whenever the machine is idle, `sda_oe` is 0 (SDA released).
- R2: The device byte is {4'b1010, dev_sel[1], dev_sel[0], A16, R/W}, most significant bit first. The block acknowledges it (SDA low during the ninth clock) only when the top nibble is 1010 and bits 3:2 equal `dev_sel`. Otherwise it leaves SDA high.
- R3: A byte write is the device byte with R/W=0, then address bits 15:8, then bits 7:0, then one data byte. Each byte is acknowledged and the data is stored at {A16, addr[15:0]}.
- R4: In a page write, each further data byte is stored at the next address. Only address bits 7:0 advance, and they wrap within the same 256-byte page. A partial page is accepted.
- R5: A random read (dummy write of the address, repeated START, device byte with R/W=1) returns the byte at that address.
- R6: A sequential read advances the full 17-bit address after each byte and wraps from 0x1FFFF to 0x00000. A master NACK ends the read.
- R7: A current-address read returns the byte one past the last byte read.
- R8: A STOP after at least one committed data byte starts a write cycle of `WR_CYCLES` clocks. During that cycle the device byte is not acknowledged.
- R9: While `wp_i` is 1, write data bytes are still acknowledged but nothing is stored and no write cycle starts.
- R10: `sda_oe` is asserted only while SCL is low. Read data changes only after a falling SCL edge, and SDA is sampled on rising edges.
- R11: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel | input | 2 | Strap bits compared with device byte bits 3:2 |
| wp_i | input | 1 | Write protect, 1 inhibits all array writes |

## Verification
Two situations are the hardest to reach from the ports. The first is the window where the self-timed cycle is still running: the bench must send a new device byte right after the STOP of a committed write, before `WR_CYCLES` has elapsed, and expect a NACK. The second is the 17-bit wrap: it is reached by first writing location 0x1FFFF, then starting a random read there and continuing with a master ACK so that the counter rolls over to location 0. Write protect is proven by overwriting an aliased address with protection on, then reading back the old value, right after checking that no busy window followed.

// File: rtl/eep2w_pkg.sv
package eep2w_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK,
        ST_ALO, ST_ALO_ACK, ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK
    } ph_e;
    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/tw_glitch_filt.sv
module tw_glitch_filt #(
    parameter int unsigned FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned FW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [FW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == filt_o) begin
                run_q <= '0;
            end else if (run_q == FW'(FILT_CYC - 1)) begin
                filt_o <= sync_q[1];
                run_q  <= '0;
            end else begin
                run_q <= run_q + FW'(1);
            end
        end
    end

    // R11: output only moves to a value the synchronised input holds
    assert_filt_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> (filt_o == $past(sync_q[1])));
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        scl_rise = !scl_p && scl_f;
        scl_fall = scl_p && !scl_f;
        start_ev = scl_p && scl_f && sda_p && !sda_f;
        stop_ev  = scl_p && scl_f && !sda_p && sda_f;
    end
endmodule

// File: rtl/wr_cycle_timer.sv
module wr_cycle_timer #(
    parameter int unsigned WR_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      left_q <= '0;
        else if (go_i)   left_q <= CW'(WR_CYCLES);
        else if (busy_o) left_q <= left_q - CW'(1);
    end

    assign busy_o = (left_q != '0);

    // R8: a started cycle is busy on the next clock
    assert_busy_after_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> busy_o);
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
    import eep2w_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned ARRAY_AW  = 11,
    parameter int unsigned PAGE_AW   = 8,
    parameter int unsigned FILT_CYC  = 3,
    parameter int unsigned WR_CYCLES = 625000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] dev_sel,
    input  logic       wp_i
);
    localparam int unsigned HI_W  = ADDR_W - 9;
    localparam int unsigned DEPTH = 1 << ARRAY_AW;

    logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
    logic busy, wc_go;

    ph_e              st, nxt;
    logic [7:0]       sh_q, tx_q, ahi_q;
    logic [3:0]       bcnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic             rw_q, msb_q, wr_pend_q;
    logic [7:0]       mem [DEPTH];

    logic got8, dev_match, mem_we, load_rd, ev;

    tw_glitch_filt #(.FILT_CYC(FILT_CYC)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .filt_o(scl_f));
    tw_glitch_filt #(.FILT_CYC(FILT_CYC)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .filt_o(sda_f));
    tw_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev));
    wr_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go_i(wc_go), .busy_o(busy));

    // next-state logic and strobes
    always_comb begin
        ev        = start_ev || stop_ev;
        got8      = (bcnt_q == 4'd8);
        dev_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:2] == dev_sel);
        mem_we    = !ev && (st == ST_WDAT) && scl_fall && got8 && !wp_i;
        load_rd   = !ev && scl_fall &&
                    (((st == ST_DEV_ACK) && rw_q) || (st == ST_RACK));
        wc_go     = stop_ev && wr_pend_q;
        nxt       = st;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_DEV;
        end else begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_DEV:      if (scl_fall && got8)
                                 nxt = (dev_match && !busy) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:  if (scl_fall) nxt = rw_q ? ST_RDAT : ST_AHI;
                ST_AHI:      if (scl_fall && got8) nxt = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall) nxt = ST_ALO;
                ST_ALO:      if (scl_fall && got8) nxt = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall) nxt = ST_WDAT;
                ST_WDAT:     if (scl_fall && got8) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) nxt = ST_WDAT;
                ST_RDAT:     if (scl_fall && bcnt_q == 4'd7) nxt = ST_RACK;
                ST_RACK:     if (scl_rise && sda_f) nxt = ST_IDLE;
                             else if (scl_fall) nxt = ST_RDAT;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            sh_q      <= '0;
            tx_q      <= '0;
            ahi_q     <= '0;
            bcnt_q    <= '0;
            addr_q    <= '0;
            rw_q      <= 1'b0;
            msb_q     <= 1'b0;
            wr_pend_q <= 1'b0;
        end else if (ev) begin
            sda_oe <= 1'b0;
            bcnt_q <= '0;
            if (stop_ev) wr_pend_q <= 1'b0;
        end else begin
            unique case (st)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        sh_q   <= {sh_q[6:0], sda_f};
                        bcnt_q <= bcnt_q + 4'd1;
                    end else if (scl_fall && got8) begin
                        bcnt_q <= '0;
                        sda_oe <= (nxt != ST_IDLE);
                        if (st == ST_DEV) begin
                            rw_q <= sh_q[0];
                            if (!sh_q[0]) msb_q <= sh_q[1];
                        end
                        if (st == ST_AHI) ahi_q <= sh_q;
                        if (st == ST_ALO) addr_q <= {msb_q, ahi_q[HI_W-1:0], sh_q};
                        if (mem_we) begin
                            wr_pend_q <= 1'b1;
                            addr_q    <= {addr_q[ADDR_W-1:PAGE_AW],
                                          addr_q[PAGE_AW-1:0] + PAGE_AW'(1)};
                        end
                    end
                end
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK, ST_RACK: begin
                    if (scl_fall) begin
                        bcnt_q <= '0;
                        sda_oe <= 1'b0;
                        if (load_rd) begin
                            tx_q   <= mem[addr_q[ARRAY_AW-1:0]];
                            sda_oe <= !mem[addr_q[ARRAY_AW-1:0]][7];
                            addr_q <= addr_q + ADDR_W'(1);
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (bcnt_q == 4'd7) begin
                            sda_oe <= 1'b0;
                        end else begin
                            tx_q   <= {tx_q[6:0], 1'b0};
                            sda_oe <= !tx_q[6];
                            bcnt_q <= bcnt_q + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // behavioural array
    always_ff @(posedge clk) begin
        if (mem_we) mem[addr_q[ARRAY_AW-1:0]] <= sh_q;
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);
    assert_dev_ack_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEV_ACK) |-> ((sh_q[7:4] == DEV_TYPE) && (sh_q[3:2] == dev_sel)));
    assert_page_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr_q[ADDR_W-1:PAGE_AW] == $past(addr_q[ADDR_W-1:PAGE_AW])));
    assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_rd |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
    assert_busy_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEV_ACK) |-> !busy);
    assert_wp_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wp_i |-> !mem_we);
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);
endmodule

// File: tb/eep2w_slave_tb.sv
module eep2w_slave_tb_top;
    typedef struct {
        int         req;
        logic [7:0] v;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_rel = 1'b1;
    logic       wp = 1'b0;
    logic [1:0] sel = 2'b10;
    logic       sda_oe;
    logic       sda_line;

    item_t exp_q[$];
    item_t obs_q[$];
    item_t eo, oo;
    int    vecs = 0;
    int    fails = 0;
    int    r10_bad = 0;
    logic  oe_prev = 1'b0;
    bit    done = 1'b0;

    localparam int unsigned WRC = 3000;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line = m_rel & ~sda_oe;

    eep2w_slave #(.WR_CYCLES(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_sel(sel), .wp_i(wp));

    // monitor: pops observed and expected items in order
    always @(negedge clk) begin
        if (sda_oe && !oe_prev && scl) r10_bad++;
        oe_prev = sda_oe;
        if (obs_q.size() != 0 && exp_q.size() != 0) begin
            oo = obs_q.pop_front();
            eo = exp_q.pop_front();
            vecs++;
            if (oo.v !== eo.v) begin
                fails++;
                $display("FAIL R%0d: got %h expected %h", eo.req, oo.v, eo.v);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cyc(input logic val, input bit glitch, output logic got);
        wait_clk(5);
        m_rel = val;
        wait_clk(5);
        if (glitch) begin
            scl = 1'b1;
            wait_clk(1);
            scl = 1'b0;
            wait_clk(9);
        end else begin
            wait_clk(10);
        end
        scl = 1'b1;
        wait_clk(10);
        got = sda_line;
        wait_clk(10);
        scl = 1'b0;
    endtask

    task automatic do_start();
        wait_clk(5);
        m_rel = 1'b1;
        wait_clk(15);
        scl = 1'b1;
        wait_clk(20);
        m_rel = 1'b0;
        wait_clk(20);
        scl = 1'b0;
    endtask

    task automatic do_stop();
        wait_clk(5);
        m_rel = 1'b0;
        wait_clk(15);
        scl = 1'b1;
        wait_clk(20);
        m_rel = 1'b1;
        wait_clk(20);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                             input int req, input bit glitch);
        logic g;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], glitch, g);
        bit_cyc(1'b1, 1'b0, g);
        exp_q.push_back('{req, {7'b0, exp_ack}});
        obs_q.push_back('{req, {7'b0, g}});
    endtask

    task automatic read_byte(input logic [7:0] expv, input logic m_ack,
                             input int req, input bit record);
        logic [7:0] d;
        logic g;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, 1'b0, g);
            d[i] = g;
        end
        bit_cyc(!m_ack, 1'b0, g);
        if (record) begin
            exp_q.push_back('{req, expv});
            obs_q.push_back('{req, d});
        end
    endtask

    function automatic logic [7:0] devb(input logic msb, input logic rd);
        return {4'b1010, sel, msb, rd};
    endfunction

    task automatic set_addr(input logic [16:0] a, input int req);
        do_start();
        send_byte(devb(a[16], 1'b0), 1'b0, req, 1'b0);
        send_byte(a[15:8], 1'b0, req, 1'b0);
        send_byte(a[7:0], 1'b0, req, 1'b0);
    endtask

    task automatic rand_read(input logic [16:0] a, input logic [7:0] expv, input int req);
        set_addr(a, req);
        do_start();
        send_byte(devb(1'b0, 1'b1), 1'b0, req, 1'b0);
        read_byte(expv, 1'b0, req, 1'b1);
        do_stop();
    endtask

    initial begin
        wait_clk(10);
        // R1: released after reset
        exp_q.push_back('{1, 8'h00});
        obs_q.push_back('{1, {7'b0, sda_oe}});
        rst_n = 1'b1;
        wait_clk(20);
        exp_q.push_back('{1, 8'h00});
        obs_q.push_back('{1, {7'b0, sda_oe}});

        // R2: wrong strap bits get a NACK
        do_start();
        send_byte({4'b1010, 2'b01, 1'b0, 1'b0}, 1'b1, 2, 1'b0);
        do_stop();
        // R2: wrong device type nibble gets a NACK
        do_start();
        send_byte({4'b1011, sel, 1'b0, 1'b0}, 1'b1, 2, 1'b0);
        do_stop();

        // R3 byte write to 0x10005, R11 SCL glitches inside each data bit
        set_addr(17'h10005, 3);
        send_byte(8'hA5, 1'b0, 3, 1'b1);
        do_stop();
        // R8: device byte during the write cycle is not acknowledged
        do_start();
        send_byte(devb(1'b0, 1'b0), 1'b1, 8, 1'b0);
        do_stop();
        wait_clk(WRC + 200);

        // R5 random read, R11 value unaffected by glitches
        rand_read(17'h10005, 8'hA5, 5);

        // R4 partial page crossing 0xFF -> 0x00 in the same page
        set_addr(17'h000FE, 4);
        send_byte(8'h11, 1'b0, 4, 1'b0);
        send_byte(8'h22, 1'b0, 4, 1'b0);
        send_byte(8'h33, 1'b0, 4, 1'b0);
        do_stop();
        wait_clk(WRC + 200);
        rand_read(17'h00000, 8'h33, 4);
        rand_read(17'h000FE, 8'h11, 4);
        // R7 current-address read continues at 0xFF
        do_start();
        send_byte(devb(1'b0, 1'b1), 1'b0, 7, 1'b0);
        read_byte(8'h22, 1'b0, 7, 1'b1);
        do_stop();

        // R6 sequential read wrapping 0x1FFFF -> 0x00000
        set_addr(17'h1FFFF, 6);
        send_byte(8'h77, 1'b0, 6, 1'b0);
        do_stop();
        wait_clk(WRC + 200);
        set_addr(17'h1FFFF, 6);
        do_start();
        send_byte(devb(1'b0, 1'b1), 1'b0, 6, 1'b0);
        read_byte(8'h77, 1'b1, 6, 1'b1);
        read_byte(8'h33, 1'b0, 6, 1'b1);
        do_stop();

        // R9 protected write to aliased 0x00005: acked, no busy, no store
        wp = 1'b1;
        set_addr(17'h00005, 9);
        send_byte(8'h3C, 1'b0, 9, 1'b0);
        do_stop();
        do_start();
        send_byte(devb(1'b0, 1'b1), 1'b0, 9, 1'b0);
        read_byte(8'h00, 1'b0, 9, 1'b0);
        do_stop();
        wp = 1'b0;
        rand_read(17'h10005, 8'hA5, 9);

        // R10: SDA pulled low only while SCL low
        wait_clk(20);
        exp_q.push_back('{10, 8'h00});
        obs_q.push_back('{10, r10_bad[7:0]});
        wait_clk(20);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule